// File: doc/BRIEF.md
# Width-Configurable Asynchronous SRAM Controller

This block is a synchronous controller for an asynchronous static RAM array made of four byte-wide banks. The banks share one set of address lines and one output enable. Each bank has its own chip select and write enable. A host issues single read or write requests, each with an address, write data and a width mode. The same array is then seen as a 32-bit, a 16-bit or an 8-bit wide memory, and the low host address bits choose the bank pair or the single bank. The controller picks the active lanes and moves data between the host bits and the lanes. It times the strobes with cycle counts set by parameters, so that the array's access time, write pulse width, minimum cycle time and bus turnaround are all met.

The host side uses a valid/ready handshake. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` stays low until the access and its cycle-time padding are over. A one-cycle `done` pulse marks the end of each access, and for a read it arrives together with the returned data. When the controller is idle, every strobe is inactive (high), so the array sits in its low-power standby state. Data pads appear as a separate output-enable signal, `mem_dout_en`.

Top module: `sramc_top`

## Requirements
- R1: While idle, including during reset and in the cycles after it: `req_ready` is 1, all `mem_cs_n`, all `mem_we_n` and `mem_oe_n` are 1, `mem_dout_en` is 0 and `rdata` is zero after reset.
- R2: For mode 2'b10 (and mode 2'b11, which acts the same), all four chip selects are active, the bank address is host address bits [14:0], write data passes straight through, and a read returns all 32 lane bits.
- R3: For mode 2'b01, host address bit 0 picks a lane pair (0 selects lanes on bits 15:0, 1 selects lanes on bits 31:16), and the bank address is host bits [15:1]. Write data bits 15:0 are driven onto both halves. A read returns the selected half on `rdata[15:0]`, with the upper bits zero.
- R4: For mode 2'b00, host address bits [1:0] pick one lane (value n selects bits 8n+7:8n), and the bank address is host bits [16:2]. The write byte is driven onto all four lanes. A read returns the selected byte on `rdata[7:0]`, with the upper bits zero.
- R5: A read holds the selected chip selects and `mem_oe_n` low for RD_WAIT_CLK cycles. During the read, every write enable stays high, the data drivers are off and the address is stable.
- R6: A write holds the selected chip selects and write enables low together for WR_PULSE_CLK cycles. During the write, `mem_oe_n` is high and `mem_dout_en` is 1 with the steered data driven, and no write enable is active on an unselected lane.
- R7: `done` is high for exactly one cycle, the cycle right after the last strobe cycle. For a read, `rdata` holds the captured data from that cycle on.
- R8: Two strobe phases start no less than CYC_CLK cycles apart, and `req_ready` stays low until that much time has passed.
- R9: A write that follows a read first spends TURN_CLK cycles with all strobes inactive and the drivers off. The drivers are never enabled while `mem_oe_n` is low.
- R10: A request raised while `req_ready` is low is ignored: it starts no access and writes nothing into the array.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host request valid |
| req_ready | output | 1 | Controller can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_mode | input | 2 | 00 = 8-bit, 01 = 16-bit, 10/11 = 32-bit |
| req_addr | input | BANK_AW+2 | Host address in units of the selected width |
| req_wdata | input | 4*LANE_W | Write data, right-justified |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 4*LANE_W | Read data, right-justified |
| mem_addr | output | BANK_AW | Shared bank address |
| mem_cs_n | output | 4 | Per-lane chip select, active low |
| mem_we_n | output | 4 | Per-lane write enable, active low |
| mem_oe_n | output | 1 | Shared output enable, active low |
| mem_dout | output | 4*LANE_W | Data toward the array pads |
| mem_dout_en | output | 1 | Pad driver enable for mem_dout |
| mem_din | input | 4*LANE_W | Data from the array pads |

## Verification
Full-width writes and reads on one location set the baseline timing. Sixteen-bit writes to both halves of one location, read back whole and by half, separate pair selection from data replication. Four byte writes to the lanes of one location, read back as a word and as a single byte, show whether each lane index lands on its own byte. The top address in byte mode and the reserved mode value probe the address edges. Requests that are held high while the controller is busy, and then read back at their target address, show whether a busy request leaks into the array. Write-after-read and back-to-back sequences test the turnaround gap and the minimum cycle spacing.

// File: rtl/sramc_pkg.sv
package sramc_pkg;

  localparam int LANES = 4;

  typedef enum logic [1:0] {
    MODE_X8   = 2'b00,
    MODE_X16  = 2'b01,
    MODE_X32  = 2'b10,
    MODE_X32B = 2'b11
  } width_mode_e;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_TURN  = 3'd1,
    ST_READ  = 3'd2,
    ST_WRITE = 3'd3,
    ST_RECOV = 3'd4
  } seq_state_e;

endpackage

// File: rtl/sramc_lane_map.sv
module sramc_lane_map
  import sramc_pkg::*;
#(
  parameter int BANK_AW = 15
) (
  input  logic [1:0]         mode,
  input  logic [BANK_AW+1:0] haddr,
  output logic [BANK_AW-1:0] bank_addr,
  output logic [LANES-1:0]   lane_en,
  output logic [1:0]         lane_idx
);

  logic is8, is16;

  assign is8  = (mode == MODE_X8);
  assign is16 = (mode == MODE_X16);

  always_comb begin
    if (is8) begin
      bank_addr = haddr[BANK_AW+1:2];
      lane_idx  = haddr[1:0];
    end else if (is16) begin
      bank_addr = haddr[BANK_AW:1];
      lane_idx  = {haddr[0], 1'b0};
    end else begin
      bank_addr = haddr[BANK_AW-1:0];
      lane_idx  = 2'b00;
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    localparam logic [1:0] GI = 2'(g);
    assign lane_en[g] = is8  ? (lane_idx == GI) :
                        is16 ? (lane_idx[1] == GI[1]) : 1'b1;
  end

endmodule

// File: rtl/sramc_steer.sv
module sramc_steer
  import sramc_pkg::*;
#(
  parameter int LANE_W = 8,
  localparam int DATA_W = LANES * LANE_W
) (
  input  logic [1:0]        mode,
  input  logic [1:0]        lane_idx,
  input  logic [DATA_W-1:0] host_wdata,
  input  logic [DATA_W-1:0] arr_din,
  output logic [DATA_W-1:0] arr_dout,
  output logic [DATA_W-1:0] host_rdata
);

  logic is8, is16;

  assign is8  = (mode == MODE_X8);
  assign is16 = (mode == MODE_X16);

  // write side: replicate the narrow value on every lane
  for (genvar g = 0; g < LANES; g++) begin : g_wlane
    localparam int PAIR = g % 2;
    assign arr_dout[g*LANE_W +: LANE_W] =
      is8  ? host_wdata[0 +: LANE_W] :
      is16 ? host_wdata[PAIR*LANE_W +: LANE_W] :
             host_wdata[g*LANE_W +: LANE_W];
  end

  // read side: right-justify the selected lane(s), zero above
  always_comb begin
    host_rdata = '0;
    if (is8) begin
      host_rdata[LANE_W-1:0] = arr_din[lane_idx*LANE_W +: LANE_W];
    end else if (is16) begin
      host_rdata[2*LANE_W-1:0] = arr_din[lane_idx[1]*2*LANE_W +: 2*LANE_W];
    end else begin
      host_rdata = arr_din;
    end
  end

endmodule

// File: rtl/sramc_seq.sv
module sramc_seq
  import sramc_pkg::*;
#(
  parameter int CYC_CLK      = 5,
  parameter int RD_WAIT_CLK  = 5,
  parameter int WR_PULSE_CLK = 4,
  parameter int TURN_CLK     = 2,
  localparam int CNT_W = $clog2(CYC_CLK + RD_WAIT_CLK + WR_PULSE_CLK + TURN_CLK + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic start_wr,
  output logic ready,
  output logic rd_next,
  output logic wr_next,
  output logic capture,
  output logic done
);

  seq_state_e       state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] cyc_q, cyc_d;
  logic             after_rd_q, after_rd_d;
  logic             done_q, done_d;

  assign ready   = (state_q == ST_IDLE);
  assign capture = (state_q == ST_READ) && (cnt_q == '0);
  assign rd_next = (state_d == ST_READ);
  assign wr_next = (state_d == ST_WRITE);
  assign done    = done_q;

  always_comb begin
    state_d    = state_q;
    cnt_d      = cnt_q;
    cyc_d      = (cyc_q != '0) ? cyc_q - 1'b1 : cyc_q;
    after_rd_d = after_rd_q;
    done_d     = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start) begin
          if (start_wr && after_rd_q) begin
            state_d = ST_TURN;
            cnt_d   = CNT_W'(TURN_CLK - 1);
          end else if (start_wr) begin
            state_d = ST_WRITE;
            cnt_d   = CNT_W'(WR_PULSE_CLK - 1);
            cyc_d   = CNT_W'(CYC_CLK - 1);
          end else begin
            state_d = ST_READ;
            cnt_d   = CNT_W'(RD_WAIT_CLK - 1);
            cyc_d   = CNT_W'(CYC_CLK - 1);
          end
        end
      end
      ST_TURN: begin
        if (cnt_q == '0) begin
          state_d = ST_WRITE;
          cnt_d   = CNT_W'(WR_PULSE_CLK - 1);
          cyc_d   = CNT_W'(CYC_CLK - 1);
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      ST_READ, ST_WRITE: begin
        if (cnt_q == '0) begin
          done_d     = 1'b1;
          after_rd_d = (state_q == ST_READ);
          state_d    = (cyc_q == '0) ? ST_IDLE : ST_RECOV;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      ST_RECOV: begin
        if (cyc_q == '0) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      cnt_q      <= '0;
      cyc_q      <= '0;
      after_rd_q <= 1'b0;
      done_q     <= 1'b0;
    end else begin
      state_q    <= state_d;
      cnt_q      <= cnt_d;
      cyc_q      <= cyc_d;
      after_rd_q <= after_rd_d;
      done_q     <= done_d;
    end
  end

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q) else $error("done longer than one cycle"); // R7

  AST_TURN_FROM_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_TURN) && (cnt_q == CNT_W'(TURN_CLK - 1)) |-> $past(state_q) == ST_IDLE)
    else $error("turnaround not entered from idle"); // R9

endmodule

// File: rtl/sramc_top.sv
module sramc_top
  import sramc_pkg::*;
#(
  parameter int BANK_AW      = 15,
  parameter int LANE_W       = 8,
  parameter int CYC_CLK      = 5,
  parameter int RD_WAIT_CLK  = 5,
  parameter int WR_PULSE_CLK = 4,
  parameter int TURN_CLK     = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      req_valid,
  output logic                      req_ready,
  input  logic                      req_write,
  input  logic [1:0]                req_mode,
  input  logic [BANK_AW+1:0]        req_addr,
  input  logic [4*LANE_W-1:0]       req_wdata,
  output logic                      done,
  output logic [4*LANE_W-1:0]       rdata,
  output logic [BANK_AW-1:0]        mem_addr,
  output logic [3:0]                mem_cs_n,
  output logic [3:0]                mem_we_n,
  output logic                      mem_oe_n,
  output logic [4*LANE_W-1:0]       mem_dout,
  output logic                      mem_dout_en,
  input  logic [4*LANE_W-1:0]       mem_din
);

  localparam int DATA_W = LANES * LANE_W;
  localparam int CHK_W  = $clog2(CYC_CLK + RD_WAIT_CLK + WR_PULSE_CLK + TURN_CLK + 1) + 1;
  localparam logic [CHK_W-1:0] CHK_MAX = '1;

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_n_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_s = rst_sync_q[1];

  // request decode
  logic [BANK_AW-1:0] map_addr;
  logic [LANES-1:0]   map_lanes;
  logic [1:0]         map_idx;
  logic               accept;

  sramc_lane_map #(.BANK_AW(BANK_AW)) u_map (
    .mode      (req_mode),
    .haddr     (req_addr),
    .bank_addr (map_addr),
    .lane_en   (map_lanes),
    .lane_idx  (map_idx)
  );

  // sequencer
  logic seq_ready, rd_next, wr_next, capture;

  sramc_seq #(
    .CYC_CLK      (CYC_CLK),
    .RD_WAIT_CLK  (RD_WAIT_CLK),
    .WR_PULSE_CLK (WR_PULSE_CLK),
    .TURN_CLK     (TURN_CLK)
  ) u_seq (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .start    (accept),
    .start_wr (req_write),
    .ready    (seq_ready),
    .rd_next  (rd_next),
    .wr_next  (wr_next),
    .capture  (capture),
    .done     (done)
  );

  assign accept    = req_valid && seq_ready;
  assign req_ready = seq_ready;

  // latched request
  logic [BANK_AW-1:0] addr_q,  addr_d;
  logic [LANES-1:0]   lanes_q, lanes_d;
  logic [1:0]         idx_q,   idx_d;
  logic [1:0]         mode_q,  mode_d;
  logic [DATA_W-1:0]  wdata_q, wdata_d;
  logic [DATA_W-1:0]  rdata_q, rdata_d;
  logic [DATA_W-1:0]  steer_dout, steer_rdata;

  sramc_steer #(.LANE_W(LANE_W)) u_steer (
    .mode       (mode_q),
    .lane_idx   (idx_q),
    .host_wdata (wdata_q),
    .arr_din    (mem_din),
    .arr_dout   (steer_dout),
    .host_rdata (steer_rdata)
  );

  // registered strobes
  logic [LANES-1:0] cs_n_q, cs_n_d;
  logic [LANES-1:0] we_n_q, we_n_d;
  logic             oe_n_q, oe_n_d;
  logic             den_q,  den_d;

  always_comb begin
    addr_d  = accept ? map_addr  : addr_q;
    lanes_d = accept ? map_lanes : lanes_q;
    idx_d   = accept ? map_idx   : idx_q;
    mode_d  = accept ? req_mode  : mode_q;
    wdata_d = accept ? req_wdata : wdata_q;
    rdata_d = capture ? steer_rdata : rdata_q;
    cs_n_d  = ~(lanes_d & {LANES{rd_next | wr_next}});
    we_n_d  = ~(lanes_d & {LANES{wr_next}});
    oe_n_d  = ~rd_next;
    den_d   = wr_next;
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      addr_q  <= '0;
      lanes_q <= '0;
      idx_q   <= '0;
      mode_q  <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
      cs_n_q  <= '1;
      we_n_q  <= '1;
      oe_n_q  <= 1'b1;
      den_q   <= 1'b0;
    end else begin
      addr_q  <= addr_d;
      lanes_q <= lanes_d;
      idx_q   <= idx_d;
      mode_q  <= mode_d;
      wdata_q <= wdata_d;
      rdata_q <= rdata_d;
      cs_n_q  <= cs_n_d;
      we_n_q  <= we_n_d;
      oe_n_q  <= oe_n_d;
      den_q   <= den_d;
    end
  end

  assign mem_addr    = addr_q;
  assign mem_cs_n    = cs_n_q;
  assign mem_we_n    = we_n_q;
  assign mem_oe_n    = oe_n_q;
  assign mem_dout_en = den_q;
  assign mem_dout    = steer_dout;
  assign rdata       = rdata_q;

  // timing checkers: run lengths and gaps seen on the pins
  logic             sel_any;
  logic [CHK_W-1:0] wr_run_q, since_start_q, since_oe_q;

  assign sel_any = !(&mem_cs_n);

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      wr_run_q      <= '0;
      since_start_q <= CHK_MAX;
      since_oe_q    <= CHK_MAX;
    end else begin
      wr_run_q <= (&mem_we_n) ? '0 :
                  (wr_run_q != CHK_MAX) ? wr_run_q + 1'b1 : wr_run_q;
      if (sel_any && !$past(sel_any))  since_start_q <= '0;
      else if (since_start_q != CHK_MAX) since_start_q <= since_start_q + 1'b1;
      if (!mem_oe_n)                   since_oe_q <= '0;
      else if (since_oe_q != CHK_MAX)  since_oe_q <= since_oe_q + 1'b1;
    end
  end

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n_s)
    req_ready |-> (&mem_cs_n) && (&mem_we_n) && mem_oe_n && !mem_dout_en)
    else $error("strobe active while idle"); // R1

  AST_LANE_SHAPE: assert property (@(posedge clk) disable iff (!rst_n_s)
    sel_any |-> ($countones(~mem_cs_n) == 1) || ($countones(~mem_cs_n) == 2) ||
                ($countones(~mem_cs_n) == 4))
    else $error("illegal chip-select group"); // R2

  AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rst_n_s)
    sel_any && $past(sel_any) |-> $stable(mem_addr))
    else $error("address moved during strobe"); // R5

  AST_WE_IN_CS: assert property (@(posedge clk) disable iff (!rst_n_s)
    ((~mem_we_n) & mem_cs_n) == '0)
    else $error("write enable on unselected lane"); // R6

  AST_WR_PULSE_MIN: assert property (@(posedge clk) disable iff (!rst_n_s)
    $rose(&mem_we_n) |-> wr_run_q >= CHK_W'(WR_PULSE_CLK))
    else $error("write pulse too short"); // R6

  AST_CYCLE_SPACING: assert property (@(posedge clk) disable iff (!rst_n_s)
    sel_any && !$past(sel_any) |-> since_start_q >= CHK_W'(CYC_CLK - 1))
    else $error("cycle time violated"); // R8

  AST_NO_OE_DRIVE: assert property (@(posedge clk) disable iff (!rst_n_s)
    !(!mem_oe_n && mem_dout_en))
    else $error("drivers on while array outputs enabled"); // R9

  AST_TURN_GAP: assert property (@(posedge clk) disable iff (!rst_n_s)
    $rose(mem_dout_en) |-> since_oe_q >= CHK_W'(TURN_CLK))
    else $error("turnaround too short"); // R9

endmodule

// File: tb/sim_sramc_top.sv
module sim_sramc_top;

  localparam int CYC = 5;
  localparam int RDW = 5;
  localparam int WRP = 4;
  localparam int TRN = 2;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_write;
  logic [1:0]  req_mode;
  logic [16:0] req_addr;
  logic [31:0] req_wdata;
  logic        req_ready, done;
  logic [31:0] rdata;
  logic [14:0] mem_addr;
  logic [3:0]  mem_cs_n, mem_we_n;
  logic        mem_oe_n, mem_dout_en;
  logic [31:0] mem_dout;
  logic [31:0] mem_din = '0;

  int vectors = 0;
  int errors  = 0;
  bit last_rd = 1'b0;

  logic [7:0] arr    [int];  // array contents as stored through the pins
  logic [7:0] shadow [int];  // expected contents from host requests

  always #2 clk = ~clk;

  sramc_top #(
    .BANK_AW(15), .LANE_W(8), .CYC_CLK(CYC), .RD_WAIT_CLK(RDW),
    .WR_PULSE_CLK(WRP), .TURN_CLK(TRN)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_mode(req_mode), .req_addr(req_addr),
    .req_wdata(req_wdata), .done(done), .rdata(rdata), .mem_addr(mem_addr),
    .mem_cs_n(mem_cs_n), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
    .mem_dout(mem_dout), .mem_dout_en(mem_dout_en), .mem_din(mem_din)
  );

  // behavioural array: stores on write overlap, returns data on read
  always @(negedge clk) begin
    logic [31:0] d;
    d = '0;
    for (int l = 0; l < 4; l++) begin
      int key;
      key = l * 32768 + int'(mem_addr);
      if (!mem_cs_n[l] && !mem_we_n[l]) arr[key] = mem_dout[l*8 +: 8];
      if (!mem_cs_n[l] && !mem_oe_n && mem_we_n[l] && arr.exists(key))
        d[l*8 +: 8] = arr[key];
    end
    mem_din <= d;
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [3:0] exp_mask(input logic [1:0] md, input logic [16:0] ad);
    if (md == 2'b00)      return 4'b0001 << ad[1:0];
    else if (md == 2'b01) return ad[0] ? 4'b1100 : 4'b0011;
    else                  return 4'b1111;
  endfunction

  function automatic logic [14:0] exp_baddr(input logic [1:0] md, input logic [16:0] ad);
    if (md == 2'b00)      return ad[16:2];
    else if (md == 2'b01) return ad[15:1];
    else                  return ad[14:0];
  endfunction

  function automatic logic [31:0] exp_drive(input logic [1:0] md, input logic [31:0] wd);
    if (md == 2'b00)      return {4{wd[7:0]}};
    else if (md == 2'b01) return {2{wd[15:0]}};
    else                  return wd;
  endfunction

  function automatic logic [31:0] shadow_word(input logic [14:0] ba);
    logic [31:0] w;
    w = '0;
    for (int l = 0; l < 4; l++)
      if (shadow.exists(l * 32768 + int'(ba))) w[l*8 +: 8] = shadow[l * 32768 + int'(ba)];
    return w;
  endfunction

  function automatic logic [31:0] exp_read(input logic [1:0] md, input logic [16:0] ad,
                                           input logic [31:0] w);
    if (md == 2'b00)      return {24'h0, w[ad[1:0]*8 +: 8]};
    else if (md == 2'b01) return {16'h0, (ad[0] ? w[31:16] : w[15:0])};
    else                  return w;
  endfunction

  // one access, checked every cycle against the expected waveform;
  // called and returning on a negedge where the controller is idle
  task automatic access(input bit wr, input logic [1:0] md, input logic [16:0] ad,
                        input logic [31:0] wd, input bit junk);
    logic [3:0]  m;
    logic [14:0] ba;
    logic [31:0] drv, expr;
    string       tg;
    int          len, rem;
    m    = exp_mask(md, ad);
    ba   = exp_baddr(md, ad);
    drv  = exp_drive(md, wd);
    expr = exp_read(md, ad, shadow_word(ba));
    tg   = (md == 2'b00) ? "R4" : (md == 2'b01) ? "R3" : "R2";
    len  = wr ? WRP : RDW;
    rem  = (CYC > len) ? CYC - len : 0;

    chk("R1 idle", {req_ready, mem_cs_n, mem_we_n, mem_oe_n, mem_dout_en},
        {1'b1, 4'hF, 4'hF, 1'b1, 1'b0});
    req_valid = 1'b1; req_write = wr; req_mode = md; req_addr = ad; req_wdata = wd;
    @(negedge clk);
    req_valid = junk;
    if (junk) begin
      req_write = 1'b1; req_mode = 2'b10; req_addr = 17'h1ABCD; req_wdata = 32'hFFFF_FFFF;
    end
    if (wr && last_rd) begin
      for (int t = 0; t < TRN; t++) begin
        chk("R9 turnaround", {req_ready, mem_cs_n, mem_we_n, mem_oe_n, mem_dout_en},
            {1'b0, 4'hF, 4'hF, 1'b1, 1'b0});
        @(negedge clk);
      end
    end
    for (int i = 0; i < len; i++) begin
      if (wr) begin
        chk("R6 write strobes", {req_ready, done, mem_cs_n, mem_we_n, mem_oe_n, mem_dout_en},
            {1'b0, 1'b0, ~m, ~m, 1'b1, 1'b1});
        chk({tg, " write lanes"}, {mem_addr, mem_dout}, {ba, drv});
      end else begin
        chk("R5 read strobes", {req_ready, done, mem_cs_n, mem_we_n, mem_oe_n, mem_dout_en},
            {1'b0, 1'b0, ~m, 4'hF, 1'b0, 1'b0});
        chk({tg, " read address"}, mem_addr, ba);
      end
      @(negedge clk);
    end
    chk("R7 done", done, 1'b1);
    chk("R8 ready", {req_ready, mem_cs_n}, {(rem == 0), 4'hF});
    if (!wr) chk({tg, " read data"}, rdata, expr);
    req_valid = 1'b0;
    if (wr) begin
      for (int l = 0; l < 4; l++)
        if (m[l]) shadow[l * 32768 + int'(ba)] = drv[l*8 +: 8];
      last_rd = 1'b0;
    end else begin
      last_rd = 1'b1;
    end
    for (int j = 1; j <= rem; j++) begin
      @(negedge clk);
      if (j < rem)
        chk("R8 busy", {req_ready, done, mem_cs_n}, {1'b0, 1'b0, 4'hF});
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL R1 watchdog expired actual=running expected=finished");
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_mode = 2'b10;
    req_addr = '0; req_wdata = '0;
    repeat (3) @(negedge clk);
    chk("R1 in reset", {req_ready, done, mem_cs_n, mem_we_n, mem_oe_n, mem_dout_en},
        {1'b1, 1'b0, 4'hF, 4'hF, 1'b1, 1'b0});
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 after reset", {req_ready, done, mem_cs_n, mem_we_n, mem_oe_n, mem_dout_en, rdata},
        {1'b1, 1'b0, 4'hF, 4'hF, 1'b1, 1'b0, 32'h0});

    // R2: full width
    access(1'b1, 2'b10, 17'h00123, 32'hA1B2_C3D4, 1'b0);
    access(1'b0, 2'b10, 17'h00123, 32'h0, 1'b0);
    // R3 and R9: halves, first one after a read
    access(1'b1, 2'b01, {15'h0200, 1'b0}, 32'h1111_BEEF, 1'b0);
    access(1'b1, 2'b01, {15'h0200, 1'b1}, 32'h2222_CAFE, 1'b1);
    access(1'b0, 2'b10, {2'b00, 15'h0200}, 32'h0, 1'b0);
    access(1'b0, 2'b01, {15'h0200, 1'b1}, 32'h0, 1'b0);
    // R4: single lanes
    for (int l = 0; l < 4; l++)
      access(1'b1, 2'b00, {15'h0300, 2'(l)}, 32'(8'h11 * (l + 1)), 1'b0);
    access(1'b0, 2'b10, {2'b00, 15'h0300}, 32'h0, 1'b0);
    access(1'b0, 2'b00, {15'h0300, 2'd2}, 32'h0, 1'b0);
    // R2 with mode 11, then R4 at the top byte address
    access(1'b1, 2'b11, 17'h07FFF, 32'h5A5A_A5A5, 1'b0);
    access(1'b0, 2'b00, 17'h1FFFF, 32'h0, 1'b0);
    // R10: busy requests targeted 17'h1ABCD in 32-bit mode
    access(1'b0, 2'b01, {15'h0200, 1'b0}, 32'h0, 1'b1);
    access(1'b0, 2'b10, 17'h1ABCD, 32'h0, 1'b0);
    chk("R10 busy request ignored", rdata, 32'h0);
    repeat (3) @(negedge clk);
    chk("R1 final idle", {req_ready, mem_cs_n, mem_we_n, mem_oe_n, mem_dout_en},
        {1'b1, 4'hF, 4'hF, 1'b1, 1'b0});

    $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

endmodule